// File: doc/BRIEF.md
# Sequential Signed 16x16 Multiplier on a Shared Byte Multiplier

This block forms the exact 32-bit two's-complement product of two 16-bit operands. It has only one 8x8 unsigned multiplier and uses it four times in successive cycles. Each operand splits into a high byte and a low byte. The four byte products are placed or added into a 32-bit accumulator, and all of them are treated as unsigned. Two conditional subtractions on the upper sixteen bits then turn the unsigned product into the signed one. The upper half loses the second operand when the first operand is negative, and loses the first operand when the second operand is negative.

The operand side works as a single-beat valid/ready exchange. `start` acts as valid and `!busy` acts as ready. A request transfers on a rising clock edge where `start` is high and `busy` is low. While `busy` is high the block applies back-pressure: `start` is ignored and the operand pins are not looked at. The caller may hold `start` high, and the next request then transfers in the same cycle that `done` is high. The result side has no back-pressure. `done` is a one-cycle pulse, and `product` keeps its final value until the next request transfers.

Top module: `smul_seq`

## Requirements
- R1: While `rst_n` is low, `busy` is 0, `done` is 0 and `product` is 0.
- R2: A request with `start` high and `busy` low at a clock edge sets `busy` high and clears `product` to 0 at that same edge.
- R3: `busy` stays high for exactly six cycles after the request. On the edge where it falls, `done` rises for exactly one cycle, and `done` is never high together with `busy`.
- R4: When `done` is high, `product` equals the 32-bit two's-complement product of the accepted operands for every input pair. Examples: -32768 x -32768 = 0x40000000, -1 x -1 = 0x00000001, 32767 x -32768 = 0xC0008000.
- R5: A `start` pulse while `busy` is high is ignored. It does not restart the sequence, does not move `done`, and does not change the result.
- R6: Operands are captured when the request transfers. Changes on `op_a`/`op_b` while `busy` is high do not change the result.
- R7: The intermediate `product` values follow a fixed order. With operand a = ah:al and b = bh:bl, the value after busy cycle 1 is {16'h0, al*bl}. After cycle 2 it is {ah*bh, al*bl}. Cycle 3 adds al*bh<<8 modulo 2^32, and cycle 4 adds ah*bl<<8. Cycle 5 subtracts a from bits 31:16 if b[15] is 1. Cycle 6 subtracts b from bits 31:16 if a[15] is 1.
- R8: While the block is idle and no request transfers, `product` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request valid; accepted when `busy` is low |
| op_a | input | 16 | First signed operand |
| op_b | input | 16 | Second signed operand |
| busy | output | 1 | Sequence running; the inverse of ready |
| done | output | 1 | One-cycle pulse when `product` is final |
| product | output | 32 | Accumulator; the signed product once `done` is high |

## Verification
The bench goes after the sign corners: -32768 squared, -1 times -1, and mixed extremes. A design that skipped or swapped a sign correction would give a result that is wrong by a multiple of 2^16. A design that let the carry out of a cross-product add fall into the wrong byte would corrupt bits 31:16. The bench pulses `start` and toggles the operands in mid-sequence. A block that was not guarded by `busy`, or that read the pins live, would then restart or blend operands. It also holds `start` high across `done`, where an off-by-one in the handshake would lose or duplicate a request. Because the model is compared every cycle, a reordered partial product shows up in the intermediate values even when the final sum still agrees.

// File: rtl/smul_seq_pkg.sv
package smul_seq_pkg;
  localparam int unsigned HALF_W = 8;
  localparam int unsigned OP_W   = 2 * HALF_W;
  localparam int unsigned RES_W  = 2 * OP_W;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LL   = 3'd1,
    ST_HH   = 3'd2,
    ST_LH   = 3'd3,
    ST_HL   = 3'd4,
    ST_FIXB = 3'd5,
    ST_FIXA = 3'd6
  } step_t;
endpackage

// File: rtl/smul_bytemul.sv
module smul_bytemul #(
  parameter int unsigned W       = 8,
  parameter bit          USE_OP  = 1'b1
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);
  localparam int unsigned PW = 2 * W;

  generate
    if (USE_OP) begin : g_op
      assign p = PW'(x) * PW'(y);
    end else begin : g_shift_add
      always_comb begin
        p = '0;
        for (int i = 0; i < W; i++) begin
          if (y[i]) p = p + (PW'(x) << i);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/smul_seq_ctrl.sv
module smul_seq_ctrl
  import smul_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  output step_t step,
  output logic  accept,
  output logic  busy,
  output logic  done
);
  step_t step_q, step_d;

  assign busy   = (step_q != ST_IDLE);
  assign accept = start && !busy;
  assign step   = step_q;

  always_comb begin
    unique case (step_q)
      ST_IDLE: step_d = start ? ST_LL : ST_IDLE;
      ST_LL:   step_d = ST_HH;
      ST_HH:   step_d = ST_LH;
      ST_LH:   step_d = ST_HL;
      ST_HL:   step_d = ST_FIXB;
      ST_FIXB: step_d = ST_FIXA;
      ST_FIXA: step_d = ST_IDLE;
      default: step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      done   <= 1'b0;
    end else begin
      step_q <= step_d;
      done   <= (step_q == ST_FIXA);
    end
  end
endmodule

// File: rtl/smul_acc.sv
module smul_acc
  import smul_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  step_t             step,
  input  logic [OP_W-1:0]   prod,
  input  logic [OP_W-1:0]   opa,
  input  logic [OP_W-1:0]   opb,
  output logic [RES_W-1:0]  res
);
  logic [OP_W-1:0]  upper;
  logic [OP_W-1:0]  sub_val;
  logic             sub_en;
  logic [OP_W-1:0]  upper_fixed;
  logic [RES_W-1:0] cross_sum;

  assign upper = res[RES_W-1:OP_W];

  // one shared subtractor serves both sign corrections
  always_comb begin
    if (step == ST_FIXB) begin
      sub_val = opa;
      sub_en  = opb[OP_W-1];
    end else begin
      sub_val = opb;
      sub_en  = opa[OP_W-1];
    end
    upper_fixed = sub_en ? (upper - sub_val) : upper;
  end

  // cross products enter at byte 1; carry out of the top byte drops
  assign cross_sum = res + (RES_W'(prod) << HALF_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= '0;
    end else if (accept) begin
      res <= '0;
    end else begin
      unique case (step)
        ST_LL:   res[OP_W-1:0]     <= prod;
        ST_HH:   res[RES_W-1:OP_W] <= prod;
        ST_LH,
        ST_HL:   res               <= cross_sum;
        ST_FIXB,
        ST_FIXA: res[RES_W-1:OP_W] <= upper_fixed;
        default: res               <= res;
      endcase
    end
  end
endmodule

// File: rtl/smul_seq.sv
module smul_seq
  import smul_seq_pkg::*;
#(
  parameter bit USE_OP_MUL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic              busy,
  output logic              done,
  output logic [RES_W-1:0]  product
);
  step_t             step;
  logic              accept;
  logic [OP_W-1:0]   a_q, b_q;
  logic [HALF_W-1:0] mul_x, mul_y;
  logic [OP_W-1:0]   mul_p;

  smul_seq_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .step   (step),
    .accept (accept),
    .busy   (busy),
    .done   (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (accept) begin
      a_q <= op_a;
      b_q <= op_b;
    end
  end

  // byte selection: low byte of a in LL/LH, low byte of b in LL/HL
  always_comb begin
    mul_x = ((step == ST_LL) || (step == ST_LH)) ? a_q[HALF_W-1:0] : a_q[OP_W-1:HALF_W];
    mul_y = ((step == ST_LL) || (step == ST_HL)) ? b_q[HALF_W-1:0] : b_q[OP_W-1:HALF_W];
  end

  smul_bytemul #(.W(HALF_W), .USE_OP(USE_OP_MUL)) u_mul (
    .x (mul_x),
    .y (mul_y),
    .p (mul_p)
  );

  smul_acc u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .step   (step),
    .prod   (mul_p),
    .opa    (a_q),
    .opb    (b_q),
    .res    (product)
  );
endmodule

// File: rtl/smul_seq_chk.sv
module smul_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [31:0] product
);
  logic [3:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 4'd1;
    else           busy_run <= '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!busy && !done && product == 32'd0)); // R1
  AST_TAKE_REQ: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R2
  AST_CLEAR_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> (product == 32'd0)); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R3
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R3
  AST_FALL_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R3
  AST_BUSY_SIX: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (busy_run == 4'd6)); // R3
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (busy_run < 4'd6)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(product)); // R8
endmodule

bind smul_seq smul_seq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/sim_smul_seq.sv
module sim_smul_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        busy, done;
  logic [31:0] product;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  smul_seq u0 (
    .clk (clk), .rst_n (rst_n), .start (start),
    .op_a (op_a), .op_b (op_b),
    .busy (busy), .done (done), .product (product)
  );

  // behavioural reference, advanced on every clock
  int          m_phase = 0;
  bit          m_busy = 0, m_done = 0;
  bit [31:0]   m_res = 0;
  bit [15:0]   qa = 0, qb = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_busy = 0; m_done = 0; m_res = 0;
    end else begin
      m_done = 0;
      case (m_phase)
        0: if (start) begin
             qa = op_a; qb = op_b; m_res = 0; m_phase = 1; m_busy = 1;
           end
        1: begin m_res[15:0]  = 16'(qa[7:0] * qb[7:0]);   m_phase = 2; end
        2: begin m_res[31:16] = 16'(qa[15:8] * qb[15:8]); m_phase = 3; end
        3: begin m_res = m_res + (32'(qa[7:0] * qb[15:8]) << 8); m_phase = 4; end
        4: begin m_res = m_res + (32'(qa[15:8] * qb[7:0]) << 8); m_phase = 5; end
        5: begin if (qb[15]) m_res[31:16] = m_res[31:16] - qa; m_phase = 6; end
        default: begin
          if (qa[15]) m_res[31:16] = m_res[31:16] - qb;
          m_phase = 0; m_busy = 0; m_done = 1;
        end
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] sprod(input logic [15:0] a, input logic [15:0] b);
    longint pa = longint'($signed(a));
    longint pb = longint'($signed(b));
    return 32'(pa * pb);
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      string tag;
      if (m_done)             tag = "R4 result";
      else if (m_phase == 1)  tag = "R2 cleared";
      else if (m_phase != 0)  tag = "R7 step";
      else                    tag = "R8 hold";
      chk("R3 busy", 32'(busy), 32'(m_busy));
      chk("R3 done", 32'(done), 32'(m_done));
      chk(tag, product, m_res);
      if (m_done) chk("R4 signed", product, sprod(qa, qb));
    end
  end

  task automatic do_op(input logic [15:0] a, input logic [15:0] b, input int mode);
    while (busy) @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mode != 0) begin
      op_a = ~a; op_b = a ^ b ^ 16'h5a5a;
      if (mode == 2) start = 1'b1;
      repeat (2) @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    if (mode == 1) chk("R6 captured", product, sprod(a, b));
    if (mode == 2) chk("R5 ignored", product, sprod(a, b));
    @(negedge clk);
  endtask

  initial begin
    int unsigned seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 product", product, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    do_op(16'h8000, 16'h8000, 0);
    do_op(16'hFFFF, 16'hFFFF, 0);
    do_op(16'h7FFF, 16'h8000, 0);
    do_op(16'h7FFF, 16'h7FFF, 0);
    do_op(16'h0001, 16'hFFFF, 0);
    do_op(16'h0000, 16'h8000, 0);
    do_op(16'h00FF, 16'h00FF, 0);
    do_op(16'hFF00, 16'h00FF, 0);
    do_op(16'h8001, 16'hFF01, 1);
    do_op(16'h1234, 16'hFEDC, 2);
    for (int i = 0; i < 300; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      do_op(seed[31:16], seed[15:0] ^ seed[27:12], i % 3);
    end
    // hold the request high across several completions
    op_a = 16'hC000; op_b = 16'h9ABC; start = 1'b1;
    repeat (30) @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule